// File: doc/BRIEF.md
# BCD Time-of-Day Counter Chain

This block keeps wall-clock time as six binary-coded decimal digits (hours, minutes, seconds) from a 32.768 kHz reference. A 15-bit prescaler, split into five 3-bit synchronous stages, divides the reference down to a one-second period. It produces a 50% duty-cycle 1 Hz square wave and a single-cycle tick at the end of each second. The tick advances a chain of digit counters. Each digit enables the one above it only in the cycle in which it wraps, and all registers share the reference clock.

Two set pulses, each one reference cycle wide, let the user adjust the time. A minute pulse advances the minute field by one and clears the seconds. An hour pulse advances the hour field by one. Neither pulse carries into the next field. The block has no state machine. Its only sequencing is the enable chain through the prescaler stages and through the digits.

Top module: `rtc_clock_chain`

## Requirements
- R1: While the active-low asynchronous reset is asserted, and on the first cycle after release, all six digits read 0 and `sq_1hz` and `sec_tick` are low.
- R2: `sec_tick` is high for exactly one cycle out of every 2^(3*STAGES) cycles (32768 by default). After reset it first goes high once 2^(3*STAGES)-1 rising edges have passed.
- R3: `sq_1hz` is the most significant prescaler bit. It is low for the first half of each second-period and high for the second half.
- R4: Every ones digit counts 0 to 9 in plain binary (4'b0000 to 4'b1001). On the increment after 9 it returns to 0 and carries to its tens digit in that same cycle. No digit ever holds a value above 9.
- R5: The seconds and minutes fields count 00 to 59, with each tens digit never exceeding 5.
- R6: The hours field counts 00 to 23 and wraps from 23 to 00. The hours tens digit never exceeds 2, and when it is 2 the ones digit never exceeds 3.
- R7: A `min_set_p` pulse advances minutes by one (59 wraps to 00 without changing hours) and clears seconds to 00. The tick is ignored in that cycle.
- R8: An `hr_set_p` pulse advances hours by one (23 wraps to 00). It leaves minutes and seconds unchanged when no tick occurs in the same cycle.
- R9: A tick while the time is 23:59:59 makes the next time 00:00:00.
- R10: In a cycle with no tick and no set pulse, all six digits hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 32.768 kHz reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| min_set_p | input | 1 | One-cycle pulse: advance minutes, clear seconds |
| hr_set_p | input | 1 | One-cycle pulse: advance hours |
| sec_ones | output | 4 | Seconds ones digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| min_ones | output | 4 | Minutes ones digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| hr_ones | output | 4 | Hours ones digit, BCD |
| hr_tens | output | 4 | Hours tens digit, BCD |
| sq_1hz | output | 1 | 1 Hz square wave, 50% duty |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |

## Verification
Some properties are checked on every cycle: digit range limits, the hour limit of 23, the wrap of a full digit, that digits hold between events, that seconds clear after a minute pulse, that the time rolls over from 23:59:59, and that the tick is a single-cycle pulse followed by a prescaler restart. The bench shows what needs a reference timeline: the exact cycle of the first tick and of the square-wave edges at the full 32768 division, and the combined effect of mixed random set pulses and ticks on the whole time value. A shortened prescaler variant gives the bench enough seconds to reach the midnight rollover within its run.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] bcd_t;
    localparam bcd_t BCD_NINE = 4'd9;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int STAGES  = 5,
    parameter int STAGE_W = 3
) (
    input  logic clk_ref,
    input  logic rst_n,
    output logic tick,
    output logic sq
);
    localparam logic [STAGE_W-1:0] STAGE_MAX = '1;

    logic [STAGE_W-1:0] stage_q [STAGES];
    logic [STAGES:0]    en_chain;
    logic [STAGES-1:0]  stage_zero;

    assign en_chain[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk_ref or negedge rst_n) begin
                if (!rst_n)
                    stage_q[gi] <= '0;
                else if (en_chain[gi])
                    stage_q[gi] <= stage_q[gi] + 1'b1;
            end
            assign en_chain[gi+1] = en_chain[gi] && (stage_q[gi] == STAGE_MAX);
            assign stage_zero[gi] = (stage_q[gi] == '0);
        end
    endgenerate

    assign tick = en_chain[STAGES];
    assign sq   = stage_q[STAGES-1][STAGE_W-1];

    // R2: the terminal count is followed by a full restart of every stage
    assert_tick_restart_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        tick |=> (&stage_zero));
    // R2: tick is never two cycles wide
    assert_tick_single_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        tick |=> !tick);
    // R3: square wave falls exactly at the second boundary
    assert_sq_fall_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        tick |=> !sq);
endmodule

// File: rtl/rtc_bcd_digit.sv
module rtc_bcd_digit
    import rtc_pkg::*;
#(
    parameter bcd_t LIMIT = BCD_NINE
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic inc,
    input  logic clr,
    output bcd_t val
);
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)
            val <= '0;
        else if (clr)
            val <= '0;
        else if (inc)
            val <= (val == LIMIT) ? '0 : val + 1'b1;
    end

    // R4: a digit never leaves its range
    assert_no_overflow_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        val <= LIMIT);
    // R4: incrementing a full digit wraps it to zero
    assert_digit_wrap_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (inc && !clr && val == LIMIT) |=> (val == '0));
endmodule

// File: rtl/rtc_bcd_pair.sv
module rtc_bcd_pair
    import rtc_pkg::*;
#(
    parameter bcd_t TENS_LIMIT = 4'd5,
    parameter bcd_t FULL_TENS  = 4'd5,
    parameter bcd_t FULL_ONES  = 4'd9
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic inc,
    input  logic clr,
    output bcd_t ones,
    output bcd_t tens,
    output logic full
);
    logic field_wrap;
    logic ones_top;

    assign full       = (tens == FULL_TENS) && (ones == FULL_ONES);
    assign field_wrap = inc && full;
    assign ones_top   = (ones == BCD_NINE);

    rtc_bcd_digit #(.LIMIT(BCD_NINE)) u_ones (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .inc     (inc),
        .clr     (clr || field_wrap),
        .val     (ones)
    );

    rtc_bcd_digit #(.LIMIT(TENS_LIMIT)) u_tens (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .inc     (inc && ones_top),
        .clr     (clr || field_wrap),
        .val     (tens)
    );

    // R4: a carry from the ones digit moves the tens digit in the same step
    assert_ones_carry_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (inc && !clr && !full && ones == BCD_NINE) |=> (ones == '0 && tens != $past(tens)));
endmodule

// File: rtl/rtc_clock_chain.sv
module rtc_clock_chain #(
    parameter int STAGES  = 5,
    parameter int STAGE_W = 3
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic       min_set_p,
    input  logic       hr_set_p,
    output logic [3:0] sec_ones,
    output logic [3:0] sec_tens,
    output logic [3:0] min_ones,
    output logic [3:0] min_tens,
    output logic [3:0] hr_ones,
    output logic [3:0] hr_tens,
    output logic       sq_1hz,
    output logic       sec_tick
);
    logic sec_full, min_full, hr_full;
    logic sec_inc, sec_carry, min_inc, hr_inc;

    rtc_prescaler #(.STAGES(STAGES), .STAGE_W(STAGE_W)) u_presc (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .tick    (sec_tick),
        .sq      (sq_1hz)
    );

    assign sec_inc   = sec_tick && !min_set_p;
    assign sec_carry = sec_inc && sec_full;
    assign min_inc   = min_set_p || sec_carry;
    assign hr_inc    = hr_set_p || (sec_carry && min_full);

    rtc_bcd_pair #(.TENS_LIMIT(4'd5), .FULL_TENS(4'd5), .FULL_ONES(4'd9)) u_sec (
        .clk_ref (clk_ref), .rst_n (rst_n),
        .inc (sec_inc), .clr (min_set_p),
        .ones (sec_ones), .tens (sec_tens), .full (sec_full)
    );

    rtc_bcd_pair #(.TENS_LIMIT(4'd5), .FULL_TENS(4'd5), .FULL_ONES(4'd9)) u_min (
        .clk_ref (clk_ref), .rst_n (rst_n),
        .inc (min_inc), .clr (1'b0),
        .ones (min_ones), .tens (min_tens), .full (min_full)
    );

    rtc_bcd_pair #(.TENS_LIMIT(4'd2), .FULL_TENS(4'd2), .FULL_ONES(4'd3)) u_hr (
        .clk_ref (clk_ref), .rst_n (rst_n),
        .inc (hr_inc), .clr (1'b0),
        .ones (hr_ones), .tens (hr_tens), .full (hr_full)
    );

    // R6: hours never pass 23
    assert_hour_limit_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (hr_tens < 4'd2) || (hr_tens == 4'd2 && hr_ones <= 4'd3));
    // R7: a minute pulse leaves seconds at zero
    assert_min_set_clears_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        min_set_p |=> (sec_ones == 4'd0 && sec_tens == 4'd0));
    // R8: an hour pulse without a tick leaves minutes alone
    assert_hr_set_isolated_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (hr_set_p && !min_set_p && !sec_tick) |=> ($stable(min_ones) && $stable(min_tens)));
    // R9: midnight rollover
    assert_midnight_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (sec_tick && !min_set_p && !hr_set_p && hr_full && min_full && sec_full)
        |=> (hr_tens == 4'd0 && hr_ones == 4'd0 && min_tens == 4'd0 &&
             min_ones == 4'd0 && sec_tens == 4'd0 && sec_ones == 4'd0));
    // R10: no event, no change
    assert_hold_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!sec_tick && !min_set_p && !hr_set_p) |=>
        ($stable(sec_ones) && $stable(sec_tens) && $stable(min_ones) &&
         $stable(min_tens) && $stable(hr_ones) && $stable(hr_tens)));
endmodule

// File: tb/rtc_clock_chain_test.sv
module rtc_clock_chain_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_s = 1'b0, rst_f = 1'b0;
    logic ms = 1'b0, hs = 1'b0;
    logic [3:0] so, st, mo, mt, ho, ht;
    logic sq, tk;
    logic [3:0] f_so, f_st, f_mo, f_mt, f_ho, f_ht;
    logic f_sq, f_tk;

    int errors = 0, checks = 0;
    bit done = 0;
    int pc = 0, s = 0, m = 0, h = 0;

    rtc_clock_chain #(.STAGES(1), .STAGE_W(3)) uut (
        .clk_ref(clk), .rst_n(rst_s), .min_set_p(ms), .hr_set_p(hs),
        .sec_ones(so), .sec_tens(st), .min_ones(mo), .min_tens(mt),
        .hr_ones(ho), .hr_tens(ht), .sq_1hz(sq), .sec_tick(tk));

    rtc_clock_chain uut_full (
        .clk_ref(clk), .rst_n(rst_f), .min_set_p(1'b0), .hr_set_p(1'b0),
        .sec_ones(f_so), .sec_tens(f_st), .min_ones(f_mo), .min_tens(f_mt),
        .hr_ones(f_ho), .hr_tens(f_ht), .sq_1hz(f_sq), .sec_tick(f_tk));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int as_time(input int hh, input int mm, input int ss);
        return hh * 10000 + mm * 100 + ss;
    endfunction

    function automatic int dut_time();
        return (ht * 10 + ho) * 10000 + (mt * 10 + mo) * 100 + st * 10 + so;
    endfunction

    task automatic check_all(input string tag);
        chk(dut_time() == as_time(h, m, s), tag, dut_time(), as_time(h, m, s));
        chk(so <= 9 && mo <= 9 && ho <= 9 && st <= 5 && mt <= 5, "R4 digit range",
            dut_time(), as_time(h, m, s));
        chk(tk == (pc == 7), "R2 tick", int'(tk), int'(pc == 7));
        chk(sq == (pc >= 4), "R3 square", int'(sq), int'(pc >= 4));
    endtask

    // one clock: drive set pulses, advance the model, compare at the falling edge
    task automatic step(input bit m_set, input bit h_set, input string tag);
        bit tick_now, hcarry;
        ms = m_set; hs = h_set;
        tick_now = (pc == 7);
        hcarry = 0;
        pc = (pc + 1) % 8;
        if (m_set) begin
            m = (m + 1) % 60; s = 0;
        end else if (tick_now) begin
            s++;
            if (s == 60) begin
                s = 0; m++;
                if (m == 60) begin m = 0; hcarry = 1; end
            end
        end
        if (h_set || hcarry) h = (h + 1) % 24;
        @(posedge clk);
        @(negedge clk);
        ms = 0; hs = 0;
        check_all(tag);
    endtask

    initial begin
        int hold_h, hold_m;
        void'($urandom(32'd4417));
        @(negedge clk);
        // R1 reset state
        chk(dut_time() == 0 && !sq && !tk, "R1 reset", dut_time(), 0);
        chk(f_so == 0 && !f_sq && !f_tk, "R1 reset full", int'(f_so), 0);

        // full-length prescaler: R2 and R3 at 32768
        rst_f = 1'b1;
        repeat (16383) @(posedge clk);
        @(negedge clk);
        chk(f_sq == 1'b0, "R3 low half", int'(f_sq), 0);
        @(posedge clk); @(negedge clk);
        chk(f_sq == 1'b1, "R3 high half", int'(f_sq), 1);
        repeat (16383) @(posedge clk);
        @(negedge clk);
        chk(f_tk == 1'b1, "R2 first tick", int'(f_tk), 1);
        chk(f_so == 4'd0, "R2 seconds before tick", int'(f_so), 0);
        @(posedge clk); @(negedge clk);
        chk(f_tk == 1'b0 && f_so == 4'd1 && f_sq == 1'b0, "R2 one second",
            int'(f_so), 1);

        // short prescaler variant
        chk(dut_time() == 0, "R1 held in reset", dut_time(), 0);
        rst_s = 1'b1;
        @(posedge clk); @(negedge clk);
        pc = 1;
        chk(dut_time() == 0 && !tk, "R1 after release", dut_time(), 0);

        // R6 and R8: hours up to 23, then 23 -> 00
        while (h != 23) step(0, 1, "R8 hour set");
        while (pc == 7) step(0, 0, "R10 wait");
        hold_m = as_time(0, m, s);
        step(0, 1, "R6 hour wrap");
        chk(h == 0 && ht == 0 && ho == 0, "R6 hours 23->00", ht * 10 + ho, 0);
        chk(as_time(0, mt * 10 + mo, st * 10 + so) == hold_m, "R8 min/sec kept",
            as_time(0, mt * 10 + mo, st * 10 + so), hold_m);

        // R7: minute wrap does not touch hours
        while (m != 59) step(1, 0, "R7 minute set");
        hold_h = h;
        step(1, 0, "R7 minute wrap");
        chk(mt == 0 && mo == 0 && ht * 10 + ho == hold_h && st == 0 && so == 0,
            "R7 59->00 no hour carry", ht * 10 + ho, hold_h);

        // R9: reach 23:59:59 and roll to midnight
        while (h != 23) step(0, 1, "R8 hour set");
        while (m != 59) step(1, 0, "R7 minute set");
        while (!(h == 23 && m == 59 && s == 59 && pc == 7)) step(0, 0, "R5 count");
        chk(dut_time() == 235959, "R5 23:59:59", dut_time(), 235959);
        step(0, 0, "R9 rollover");
        chk(dut_time() == 0, "R9 midnight", dut_time(), 0);

        // R10 and mixed: constrained random set pulses
        for (int i = 0; i < 3000; i++)
            step(($urandom % 16) == 0, ($urandom % 20) == 0, "R10 random");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule